// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block models one output cell of a simple programmable array logic device. Eight product terms each take the AND of a selectable subset of a 40-bit array input vector. A mask chooses which inputs each term uses, and each term can be switched off on its own. The enabled terms are ORed into one sum. That sum passes through a polarity stage and then either goes straight to the pin or goes through a D register. The cell also decides whether its pin is driven, and it chooses which signal returns to the array as feedback.

The cell's personality comes from a five-way decode of two global mode bits and one local bit. The five results are a registered pin, a combinatorial pin with its own enable term, an always-driven combinatorial pin, a dedicated input, and an illegal setting. A second local bit sets the output polarity. An active-low synchronous reset stands in for power-up and clears the register.

Top module: `pal_macrocell`

## Requirements
- R1: Product term t is 1 when every array input whose bit in `and_mask[t*40 +: 40]` is 1 is also 1 in `term_vec`. A term whose mask is all zero is 1.
- R2: When `pt_off[t]` is 1, term t adds nothing to the OR sum, and when t is 0 it also gives an enable of 0.
- R3: The mode comes from the code {`glb_mode[0]`, `glb_mode[1]`, `loc_sel`}. The codes decode as follows:
  - 010 is registered.
  - 011 and 111 are combinatorial I/O.
  - 100 is combinatorial output.
  - 101 is dedicated input.
  - Every other code is illegal. An illegal code holds `pin_oe` at 0 and takes feedback from the cell's own pin.
- R4: `loc_pol` = 1 makes the pin follow the sum directly, and `loc_pol` = 0 makes the pin carry its inverse. This holds in both the combinatorial and the registered paths.
- R5: In combinatorial I/O mode, term 0 drives `pin_oe` and is left out of the sum. In every other mode, term 0 is an ordinary data term.
- R6: In registered mode `pin_oe` follows `oe_in`. In combinatorial-output mode it is 1, and in dedicated-input mode it is 0.
- R7: On each rising clock edge the register loads the polarity-adjusted sum, which is the sum inverted when `loc_pol` = 1. In registered mode the pin drives the inverse of the register.
- R8: A clock edge with `rst_n` low clears the register. In registered mode the pin then reads 1 and the feedback reads 0.
- R9: The feedback source depends on the mode:
  - Registered mode feeds back the register.
  - Combinatorial-output mode feeds back `adj_pin`.
  - Every other mode feeds back the cell's own pin level. That level is `pin_out` when the pin is driven and `pin_in` when it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset (power-up model) |
| glb_mode | input | 2 | Global mode bits; bit 0 and bit 1 form the upper two bits of the mode code |
| loc_sel | input | 1 | Local mode bit, lowest bit of the mode code |
| loc_pol | input | 1 | Output polarity: 1 non-inverting, 0 inverting |
| and_mask | input | 320 | Eight 40-bit input-use masks, term t at bits t*40 upward |
| pt_off | input | 8 | Per-term disable, 1 removes the term |
| term_vec | input | 40 | True/complement array input terms |
| oe_in | input | 1 | External output-enable pin, 1 enables |
| pin_in | input | 1 | Level on the cell's own pin when not driven |
| adj_pin | input | 1 | Level of the neighbouring cell's pin |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin drive enable |
| fb_out | output | 1 | Feedback value returned to the array |

## Verification
Term 0 can serve two purposes in the same cycle. It can be the enable term and, under another code, a data term, and its disable bit can also be set in that cycle. The bench sweeps every code with random term disables so that term 0 lands in each of these roles. It judges `pin_oe` and `pin_out` against a model that removes term 0 from the sum only in the I/O codes. The second collision is reset against register capture. Reset is asserted in the middle of a registered run while the inputs keep changing, and the bench checks that the cleared value, and not the captured sum, reaches the pin on the next cycle.

// File: rtl/pal_cell_pkg.sv
// Package: shared mode type and decode for the output cell.
// Assumes the code is packed as {global bit 0, global bit 1, local select}.
package pal_cell_pkg;

    typedef enum logic [2:0] {
        CELL_REG  = 3'd0,
        CELL_CIO  = 3'd1,
        CELL_COUT = 3'd2,
        CELL_DIN  = 3'd3,
        CELL_BAD  = 3'd4
    } cell_mode_e;

    // Maps the three architecture bits to a cell personality
    function automatic cell_mode_e decode_mode(input logic [2:0] code);
        cell_mode_e m;
        case (code)
            3'b010:  m = CELL_REG;
            3'b011:  m = CELL_CIO;
            3'b111:  m = CELL_CIO;
            3'b100:  m = CELL_COUT;
            3'b101:  m = CELL_DIN;
            default: m = CELL_BAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pal_term_array.sv
// Module: slice of the AND plane feeding one cell.
// Each term ANDs the inputs its mask selects; an empty mask yields 1.
// A set disable bit forces the term to 0.
module pal_term_array #(
    parameter int N_TERMS  = 8,
    parameter int N_INPUTS = 40
) (
    input  logic [N_INPUTS-1:0]         term_vec,
    input  logic [N_TERMS*N_INPUTS-1:0] and_mask,
    input  logic [N_TERMS-1:0]          pt_off,
    output logic [N_TERMS-1:0]          pt_val
);

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [N_INPUTS-1:0] row;
        // Pick this term's column of use bits
        assign row       = and_mask[t*N_INPUTS +: N_INPUTS];
        // AND of the selected inputs, gated by the disable bit
        assign pt_val[t] = ~pt_off[t] & (&(term_vec | ~row));
    end

endmodule

// File: rtl/pal_or_plane.sv
// Module: OR of the data terms. In I/O mode term 0 is steered
// to the enable path and left out of the sum.
module pal_or_plane #(
    parameter int N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] pt_val,
    input  logic               steal_first,
    output logic               sum,
    output logic               oe_term
);

    logic [N_TERMS-1:0] data_keep;

    // Build the mask of terms that count as data
    always_comb begin
        data_keep    = '1;
        data_keep[0] = ~steal_first;
    end

    assign sum     = |(pt_val & data_keep);
    assign oe_term = pt_val[0];

endmodule

// File: rtl/pal_out_stage.sv
// Module: polarity, register, enable and feedback selection.
// Assumes the mode is already decoded; the register clocks every cycle.
module pal_out_stage
    import pal_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cell_mode_e mode,
    input  logic       loc_pol,
    input  logic       sum,
    input  logic       oe_term,
    input  logic       oe_in,
    input  logic       pin_in,
    input  logic       adj_pin,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       fb_out
);

    logic q;
    logic comb_val;
    logic own_pin;

    // Combinatorial path: non-inverting when loc_pol is set
    assign comb_val = loc_pol ? sum : ~sum;

    // Register loads the value whose inverse the pin buffer shows
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ~comb_val;
    end

    // Pin value and enable per mode
    always_comb begin
        pin_out = (mode == CELL_REG) ? ~q : comb_val;
        case (mode)
            CELL_REG:  pin_oe = oe_in;
            CELL_CIO:  pin_oe = oe_term;
            CELL_COUT: pin_oe = 1'b1;
            default:   pin_oe = 1'b0;
        endcase
    end

    assign own_pin = pin_oe ? pin_out : pin_in;

    // Feedback source per mode
    always_comb begin
        case (mode)
            CELL_REG:  fb_out = q;
            CELL_COUT: fb_out = adj_pin;
            default:   fb_out = own_pin;
        endcase
    end

endmodule

// File: rtl/pal_macrocell.sv
// Module: one configurable output cell of a sum-of-products device.
// It wires the term slice, the OR plane and the output stage under the mode decode.
module pal_macrocell
    import pal_cell_pkg::*;
#(
    parameter int N_TERMS  = 8,
    parameter int N_INPUTS = 40,
    localparam int MASK_W  = N_TERMS * N_INPUTS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          glb_mode,
    input  logic                loc_sel,
    input  logic                loc_pol,
    input  logic [MASK_W-1:0]   and_mask,
    input  logic [N_TERMS-1:0]  pt_off,
    input  logic [N_INPUTS-1:0] term_vec,
    input  logic                oe_in,
    input  logic                pin_in,
    input  logic                adj_pin,
    output logic                pin_out,
    output logic                pin_oe,
    output logic                fb_out
);

    cell_mode_e         mode;
    logic [N_TERMS-1:0] pt_val;
    logic               sum;
    logic               oe_term;

    // Decode the architecture bits
    assign mode = decode_mode({glb_mode[0], glb_mode[1], loc_sel});

    pal_term_array #(.N_TERMS(N_TERMS), .N_INPUTS(N_INPUTS)) u_terms (
        .term_vec (term_vec),
        .and_mask (and_mask),
        .pt_off   (pt_off),
        .pt_val   (pt_val)
    );

    pal_or_plane #(.N_TERMS(N_TERMS)) u_or (
        .pt_val      (pt_val),
        .steal_first (mode == CELL_CIO),
        .sum         (sum),
        .oe_term     (oe_term)
    );

    pal_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .loc_pol (loc_pol),
        .sum     (sum),
        .oe_term (oe_term),
        .oe_in   (oe_in),
        .pin_in  (pin_in),
        .adj_pin (adj_pin),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb_out  (fb_out)
    );

endmodule

// File: rtl/pal_macrocell_chk.sv
// Checker: port-level properties of the output cell, bound to the top.
module pal_macrocell_chk #(
    parameter int N_TERMS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         glb_mode,
    input logic               loc_sel,
    input logic [N_TERMS-1:0] pt_off,
    input logic               oe_in,
    input logic               adj_pin,
    input logic               pin_out,
    input logic               pin_oe,
    input logic               fb_out
);

    logic [2:0] code;
    logic       was_rst;

    assign code = {glb_mode[0], glb_mode[1], loc_sel};

    // Marks the first cycle after a reset edge
    always_ff @(posedge clk) was_rst <= ~rst_n;

    // R6
    reg_oe_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b010) |-> (pin_oe == oe_in));

    // R6
    din_never_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b101) |-> !pin_oe);

    // R3
    bad_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b000 || code == 3'b001 || code == 3'b110) |-> !pin_oe);

    // R2
    off_term0_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((code == 3'b011 || code == 3'b111) && pt_off[0]) |-> !pin_oe);

    // R7
    reg_pin_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b010) |-> (fb_out != pin_out));

    // R8
    reset_clears_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst && code == 3'b010) |-> (pin_out && !fb_out));

    // R9
    cout_fb_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 3'b100) |-> (fb_out == adj_pin));

endmodule

bind pal_macrocell pal_macrocell_chk #(.N_TERMS(N_TERMS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_mode (glb_mode),
    .loc_sel  (loc_sel),
    .pt_off   (pt_off),
    .oe_in    (oe_in),
    .adj_pin  (adj_pin),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .fb_out   (fb_out)
);

// File: tb/pal_macrocell_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference compared on every clock over all codes.
module pal_macrocell_bench;

    localparam int NT = 8;
    localparam int NI = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      glb_mode = 2'b10;
    logic            loc_sel = 1'b0;
    logic            loc_pol = 1'b0;
    logic [NT*NI-1:0] and_mask = '0;
    logic [NT-1:0]   pt_off = '0;
    logic [NI-1:0]   term_vec = '0;
    logic            oe_in = 1'b0;
    logic            pin_in = 1'b0;
    logic            adj_pin = 1'b0;
    logic            pin_out, pin_oe, fb_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic q_ref = 1'b0;

    always #2.5 clk = ~clk;

    pal_macrocell u_pal_macrocell (
        .clk(clk), .rst_n(rst_n), .glb_mode(glb_mode), .loc_sel(loc_sel),
        .loc_pol(loc_pol), .and_mask(and_mask), .pt_off(pt_off),
        .term_vec(term_vec), .oe_in(oe_in), .pin_in(pin_in),
        .adj_pin(adj_pin), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // Mode number: 0 reg, 1 comb I/O, 2 comb out, 3 input, 4 illegal
    function automatic int ref_mode();
        case ({glb_mode[0], glb_mode[1], loc_sel})
            3'b010: return 0;
            3'b011, 3'b111: return 1;
            3'b100: return 2;
            3'b101: return 3;
            default: return 4;
        endcase
    endfunction

    function automatic bit term_true(int t);
        for (int b = 0; b < NI; b++)
            if (and_mask[t*NI+b] && !term_vec[b]) return 1'b0;
        return !pt_off[t];
    endfunction

    function automatic bit ref_sum();
        bit s = 1'b0;
        for (int t = 0; t < NT; t++)
            if (!(ref_mode() == 1 && t == 0) && term_true(t)) s = 1'b1;
        return s;
    endfunction

    // Reference register
    always @(posedge clk) begin
        if (!rst_n) q_ref <= 1'b0;
        else        q_ref <= loc_pol ? ~ref_sum() : ref_sum();
    end

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (code %b%b%b pol %b)",
                     tag, act, exp, glb_mode[0], glb_mode[1], loc_sel, loc_pol);
        end
    endtask

    task automatic compare_all();
        int  m    = ref_mode();
        bit  s    = ref_sum();
        bit  comb = loc_pol ? s : ~s;
        bit  oe, po, fb;
        case (m)
            0: oe = oe_in;
            1: oe = term_true(0);
            2: oe = 1'b1;
            default: oe = 1'b0;
        endcase
        po = (m == 0) ? ~q_ref : comb;
        if (m == 0)      fb = q_ref;
        else if (m == 2) fb = adj_pin;
        else             fb = oe ? po : pin_in;
        chk(m == 4 ? "R3 enable" : "R5 R6 enable", pin_oe, oe);
        chk(m == 0 ? "R7 R4 pin" : "R1 R2 R4 pin", pin_out, po);
        chk("R9 feedback", fb_out, fb);
    endtask

    task automatic drive_random();
        for (int t = 0; t < NT; t++)
            for (int b = 0; b < NI; b++)
                and_mask[t*NI+b] = ($urandom % 16) == 0;
        if ($urandom % 4 == 0) and_mask[$urandom % NT * NI +: NI] = '0;
        term_vec = {$urandom, $urandom};
        pt_off   = ($urandom % 3 == 0) ? NT'($urandom) : '0;
        oe_in    = $urandom;
        pin_in   = $urandom;
        adj_pin  = $urandom;
    endtask

    task automatic step();
        @(posedge clk);
        #1 drive_random();
        @(negedge clk);
        compare_all();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state in registered mode
        glb_mode = 2'b10; loc_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset pin", pin_out, 1'b1);
        chk("R8 reset fb", fb_out, 1'b0);
        #1 rst_n = 1'b1;
        // Sweep every code and polarity
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < 2; p++) begin
                @(posedge clk);
                #1 {glb_mode[0], glb_mode[1], loc_sel} = 3'(c);
                loc_pol = p[0];
                repeat (150) step();
            end
        end
        // R8: reset in the middle of a registered run
        @(posedge clk);
        #1 glb_mode = 2'b10; loc_sel = 1'b0; loc_pol = 1'b1;
        repeat (20) step();
        @(posedge clk);
        #1 rst_n = 1'b0; drive_random();
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R8 mid-run reset pin", pin_out, 1'b1);
        chk("R8 mid-run reset fb", fb_out, 1'b0);
        repeat (50) step();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule